// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block is a memory-mapped controller for a one-time-programmable fuse array of 8 banks, each holding 256 eight-bit words. Software reaches it through a simple word-addressed register port. The port supports three kinds of access:

- **Program one bit.** A single fuse bit is burned. The target is set by two byte-wide address registers, and a key register must be armed first.
- **Sense one word.** An explicit sense copies a whole fuse word into a sense-data register.
- **Shadow window.** Each word has a directly mapped shadow copy. Software can read it, or overwrite it for test.

The fuse array is held in flops as a behavioural model. A busy flag covers each timed cycle. Sticky done and error flags report completion, protection violations and rejected requests. Each bank has its own read-protect, override-protect and program-lock bits, held in plain registers.

Software sets the target address, writes 0xAA to the key register, and sets the program start bit. It then polls busy and checks the done and error flags. A sense works the same way but needs no key. Each bus access completes in one cycle. Read data is combinational from the address.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the following all read 0: status (word 0), status mask (word 1), error (word 2), error mask (word 3), fuse control (word 4), both address registers (words 5 and 6), sense data (word 7), key (word 10) and the three protect masks (words 11 to 13). The product and silicon revision registers (words 8 and 9) read their parameter values.
- R2: The target address is decoded as follows. The bank is upper-address bits 5:3. The word index is {upper-address bits 2:0, lower-address bits 7:3}. The bit is lower-address bits 2:0.
- R3: A program start (write to word 4 with bit 0 set) that passes all checks has these effects:
  - Busy (status bit 7) is set from the cycle after the write, for UNIT_CYC*(len+1) cycles, where len is bits 6:4 of the same write.
  - It then sets only the addressed fuse bit.
  - It sets program-done (status bit 1).
- R4: A program start while the key register (word 10) is not 0xAA sets write-protect error (error bit 6). It does not go busy and burns nothing.
- R5: Program-start checks are applied in this priority: disable first, then key, then lock. Each failure goes neither busy nor burns anything.
  - If bit 7 of the same control write is set, program error (error bit 7) is set alone.
  - Otherwise, if the key is not 0xAA, write-protect error (error bit 6) is set, as in R4.
  - Otherwise, if the target bank's bit in the program-lock mask (word 13) is set, write-lock error (error bit 3) is set.
- R6: A sense start (write to word 4 with bit 3 set and bit 0 clear) holds busy for UNIT_CYC cycles. It then loads the addressed fuse word into sense data (word 7) and sets sense-done (status bit 0).
- R7: A sense start on a bank whose bit is set in the read-protect mask (word 11) does the following:
  - It sets sense error (error bit 2).
  - It does not go busy.
  - It leaves sense data and sense-done unchanged.
- R8: A read of window word WIN_BASE + bank*256 + word returns the shadow value of that word. Completed program cycles update the shadow as well as the fuse. If the bank is read-protected, the read returns 0 and sets read-protect error (error bit 4).
- R9: A window write with write-data bits 31:8 all zero replaces the shadow word and leaves the fuse unchanged. If the bank's bit in the override-protect mask (word 12) is set, the write instead sets override-protect error (error bit 5) and leaves the shadow unchanged. A window write with any of bits 31:8 set is ignored.
- R10: Start requests while busy are ignored and do not extend the cycle. A write with both start bits set runs a program only.
- R11: Status bits 1:0 and error bits 7:1 are sticky. Writing 1 to a bit clears it, and writing 0 has no effect.
- R12: The key, error mask, status mask, address registers and protect masks read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |

## Verification
The bench goes after the following corner cases:

- **Bit decode.** Each bit index and bank is programmed, then sensed back. It includes a second bit in an already-burned word and the same word index in two banks. A design that OR-ed instead of selecting a bit, or that dropped a bank bit, returns a wrong sense value.
- **Busy length.** Busy is counted cycle by cycle for several pulse lengths. An off-by-one counter, or a restart on a second start request, shows up as a wrong count.
- **Protection checks.** The three program checks are fired in overlapping combinations. A design that set several error bits, or burned anyway, is caught when the word is read through sense.
- **Shadow versus fuse.** A design that let an override reach the fuse array, or honoured a write with upper data bits set, is caught.

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
  parameter int AW = 12,
  parameter int WIN_BASE = 'h200,
  parameter int UNIT_CYC = 4,
  parameter logic [7:0] PROD_REV = 8'h3A,
  parameter logic [7:0] SIL_REV = 8'h11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata
);
  localparam int NBANK = 8;
  localparam int NWORD = 256;
  localparam int NCELL = NBANK * NWORD;
  localparam int IDX_W = $clog2(NCELL);
  localparam int CNT_W = $clog2(UNIT_CYC * 8 + 1);
  localparam logic [AW:0] WIN_LO = (AW+1)'(WIN_BASE);

  localparam logic [AW-1:0] A_STAT = AW'(0), A_STATM = AW'(1), A_ERR = AW'(2),
    A_EMASK = AW'(3), A_CTL = AW'(4), A_UA = AW'(5), A_LA = AW'(6), A_SDAT = AW'(7),
    A_PREV = AW'(8), A_SREV = AW'(9), A_KEY = AW'(10), A_RDP = AW'(11),
    A_OVP = AW'(12), A_LCK = AW'(13);

  logic [7:0] fuse_q [NCELL];
  logic [7:0] shadow_q [NCELL];
  logic [1:0] done_q, statm_q;
  logic [7:0] err_q, emask_q, la_q, sdat_q, key_q, rdprot_q, ovprot_q, lock_q;
  logic [3:0] ctl_q;
  logic [5:0] ua_q;
  logic       busy_q, op_prog_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] tgt_idx_q;
  logic [2:0]       tgt_bit_q;

  wire wr = bus_sel & bus_wr;
  wire rd = bus_sel & ~bus_wr;
  wire hi_zero = (bus_wdata[31:8] == 24'h0);

  logic [AW:0] win_diff;
  assign win_diff = {1'b0, bus_addr} - WIN_LO;
  wire win_hit = (win_diff[AW:IDX_W] == '0);
  wire [IDX_W-1:0] win_idx = win_diff[IDX_W-1:0];
  wire [2:0] win_bank = win_idx[IDX_W-1:IDX_W-3];

  wire [IDX_W-1:0] addr_idx = {ua_q, la_q[7:3]};
  wire [2:0] addr_bank = ua_q[5:3];

  wire ctl_wr  = wr & (bus_addr == A_CTL);
  wire req_prg = ctl_wr & bus_wdata[0] & ~busy_q;
  wire req_sns = ctl_wr & bus_wdata[3] & ~bus_wdata[0] & ~busy_q;
  wire rej_dis = req_prg & bus_wdata[7];
  wire rej_key = req_prg & ~bus_wdata[7] & (key_q != 8'hAA);
  wire rej_lck = req_prg & ~bus_wdata[7] & (key_q == 8'hAA) & lock_q[addr_bank];
  wire go_prg  = req_prg & ~rej_dis & ~rej_key & ~rej_lck;
  wire rej_sns = req_sns & rdprot_q[addr_bank];
  wire go_sns  = req_sns & ~rej_sns;
  wire finish  = busy_q & (cnt_q == CNT_W'(1));

  wire rd_prot = rd & win_hit & rdprot_q[win_bank];
  wire ov_try  = wr & win_hit & hi_zero;
  wire ov_prot = ov_try & ovprot_q[win_bank];
  wire ov_do   = ov_try & ~ovprot_q[win_bank];

  wire [CNT_W-1:0] prg_dur = CNT_W'(UNIT_CYC * (int'(bus_wdata[6:4]) + 1));

  wire [7:0] err_set = {rej_dis, rej_key, ov_prot, rd_prot, rej_lck, rej_sns, 2'b00};
  wire [1:0] done_set = {finish & op_prog_q, finish & ~op_prog_q};
  wire [7:0] err_clr = (wr && bus_addr == A_ERR) ? bus_wdata[7:0] : 8'h0;
  wire [1:0] done_clr = (wr && bus_addr == A_STAT) ? bus_wdata[1:0] : 2'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0; statm_q <= '0; err_q <= '0; emask_q <= '0; ctl_q <= '0;
      ua_q <= '0; la_q <= '0; sdat_q <= '0; key_q <= '0;
      rdprot_q <= '0; ovprot_q <= '0; lock_q <= '0;
      busy_q <= 1'b0; op_prog_q <= 1'b0; cnt_q <= '0; tgt_idx_q <= '0; tgt_bit_q <= '0;
    end else begin
      done_q <= (done_q & ~done_clr) | done_set;
      err_q  <= ((err_q & ~err_clr) | err_set) & 8'hFE;
      if (wr) begin
        case (bus_addr)
          A_STATM: statm_q  <= bus_wdata[1:0];
          A_EMASK: emask_q  <= bus_wdata[7:0] & 8'hFE;
          A_CTL:   ctl_q    <= bus_wdata[7:4];
          A_UA:    ua_q     <= bus_wdata[5:0];
          A_LA:    la_q     <= bus_wdata[7:0];
          A_KEY:   key_q    <= bus_wdata[7:0];
          A_RDP:   rdprot_q <= bus_wdata[7:0];
          A_OVP:   ovprot_q <= bus_wdata[7:0];
          A_LCK:   lock_q   <= bus_wdata[7:0];
          default: ;
        endcase
      end
      if (go_prg || go_sns) begin
        busy_q    <= 1'b1;
        op_prog_q <= go_prg;
        cnt_q     <= go_prg ? prg_dur : CNT_W'(UNIT_CYC);
        tgt_idx_q <= addr_idx;
        tgt_bit_q <= la_q[2:0];
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (finish) begin
          busy_q <= 1'b0;
          if (!op_prog_q) sdat_q <= fuse_q[tgt_idx_q];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCELL; i++) begin
        fuse_q[i]   <= 8'h0;
        shadow_q[i] <= 8'h0;
      end
    end else begin
      if (finish && op_prog_q) begin
        fuse_q[tgt_idx_q]   <= fuse_q[tgt_idx_q] | (8'h1 << tgt_bit_q);
        shadow_q[tgt_idx_q] <= shadow_q[tgt_idx_q] | (8'h1 << tgt_bit_q);
      end
      if (ov_do) shadow_q[win_idx] <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (win_hit) begin
      bus_rdata[7:0] = rdprot_q[win_bank] ? 8'h0 : shadow_q[win_idx];
    end else begin
      case (bus_addr)
        A_STAT:  bus_rdata[7:0] = {busy_q, 5'b0, done_q};
        A_STATM: bus_rdata[7:0] = {6'b0, statm_q};
        A_ERR:   bus_rdata[7:0] = err_q;
        A_EMASK: bus_rdata[7:0] = emask_q;
        A_CTL:   bus_rdata[7:0] = {ctl_q, 4'b0};
        A_UA:    bus_rdata[7:0] = {2'b0, ua_q};
        A_LA:    bus_rdata[7:0] = la_q;
        A_SDAT:  bus_rdata[7:0] = sdat_q;
        A_PREV:  bus_rdata[7:0] = PROD_REV;
        A_SREV:  bus_rdata[7:0] = SIL_REV;
        A_KEY:   bus_rdata[7:0] = key_q;
        A_RDP:   bus_rdata[7:0] = rdprot_q;
        A_OVP:   bus_rdata[7:0] = ovprot_q;
        A_LCK:   bus_rdata[7:0] = lock_q;
        default: bus_rdata = 32'h0;
      endcase
    end
  end

  assert_done_on_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (done_q != 2'b00));

  assert_key_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && op_prog_q) |-> ($past(key_q) == 8'hAA));

  assert_unlocked_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && op_prog_q) |-> !$past(lock_q[ua_q[5:3]]));

  assert_busy_countdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != CNT_W'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_ERR) |=> (($past(err_q) & ~err_q) == 8'h00));

  assert_sense_unprotected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && !op_prog_q) |-> !$past(rdprot_q[ua_q[5:3]]));
endmodule

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 12;
  localparam int UNIT = 4;

  logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int n_chk = 0, n_fail = 0;
  logic done_flag = 1'b0;

  otp_fuse_ctrl #(.AW(AW), .WIN_BASE('h200), .UNIT_CYC(UNIT),
                  .PROD_REV(8'h3A), .SIL_REV(8'h11)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #(CLK_P/2) clk = ~clk;

  // fields: ua, la, len, expected sense byte
  localparam logic [31:0] VEC [6] = '{
    32'h00_00_00_01, 32'h3F_FF_07_80, 32'h12_2D_02_20,
    32'h12_2A_01_24, 32'h0A_2B_00_08, 32'h05_08_00_01 };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] s;
    n = 0;
    rd(0, s);
    while (s[7] && n < 300) begin
      n++;
      rd(0, s);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int win_addr(input logic [7:0] ua, input logic [7:0] la);
    return 'h200 + int'(ua[5:3]) * 256 + int'({ua[2:0], la[7:3]});
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 14; a++) begin
      rd(a, v);
      check(a == 8 ? "R1 prev" : a == 9 ? "R1 srev" : "R1 reset", v,
            a == 8 ? 32'h3A : a == 9 ? 32'h11 : 32'h0);
    end

    // R2 R3 R6 R8 vector table
    foreach (VEC[i]) begin
      logic [7:0] ua, la, len, ex;
      {ua, la, len, ex} = VEC[i];
      wr(10, 32'hAA); wr(5, ua); wr(6, la);
      wr(4, {24'h0, 1'b0, len[2:0], 4'h1});
      wait_idle(n);
      check("R3 program busy length", n, UNIT * (int'(len) + 1));
      rd(0, v); check("R3 program done", v, 32'h02);
      wr(0, 32'h3);
      wr(4, 32'h08);
      wait_idle(n);
      check("R6 sense busy length", n, UNIT);
      rd(0, v); check("R6 sense done", v, 32'h01);
      wr(0, 32'h3);
      rd(7, v); check("R2 R3 R6 sense data", v, {24'h0, ex});
      rd(win_addr(ua, la), v); check("R8 shadow read", v, {24'h0, ex});
    end

    // R5 priority and R4 key
    wr(5, 32'h20); wr(6, 32'h00);
    wr(10, 32'h00); wr(4, 32'h81); wait_idle(n);
    check("R5 disable no busy", n, 0);
    rd(2, v); check("R5 disable beats key", v, 32'h80);
    wr(2, 32'h00); rd(2, v); check("R11 write 0 keeps", v, 32'h80);
    wr(2, 32'hFE); rd(2, v); check("R11 write 1 clears", v, 32'h00);
    wr(4, 32'h01); wait_idle(n);
    check("R4 no busy", n, 0);
    rd(2, v); check("R4 key error", v, 32'h40);
    wr(2, 32'hFE);
    wr(10, 32'hAA); wr(13, 32'h10); wr(4, 32'h01); wait_idle(n);
    check("R5 lock no busy", n, 0);
    rd(2, v); check("R5 lock error", v, 32'h08);
    wr(2, 32'hFE); wr(13, 32'h00);
    wr(4, 32'h08); wait_idle(n);
    wr(0, 32'h3);
    rd(7, v); check("R4 R5 nothing burned", v, 32'h00);

    // R7 protected sense, R8 protected read
    wr(11, 32'h04); wr(5, 32'h12); wr(6, 32'h28);
    wr(4, 32'h08); wait_idle(n);
    check("R7 no busy", n, 0);
    rd(2, v); check("R7 sense error", v, 32'h04);
    rd(0, v); check("R7 no sense done", v, 32'h00);
    rd(7, v); check("R7 sdat kept", v, 32'h00);
    wr(2, 32'hFE);
    rd(win_addr(8'h12, 8'h28), v); check("R8 protected read zero", v, 32'h0);
    rd(2, v); check("R8 read-protect error", v, 32'h10);
    wr(2, 32'hFE); wr(11, 32'h00);

    // R9 override
    wr('h50A, 32'h5A); rd('h50A, v); check("R9 override", v, 32'h5A);
    wr('h50A, 32'h1A5); rd('h50A, v); check("R9 upper bits ignored", v, 32'h5A);
    wr(5, 32'h18); wr(6, 32'h50); wr(4, 32'h08); wait_idle(n); wr(0, 32'h3);
    rd(7, v); check("R9 fuse untouched", v, 32'h00);
    wr(12, 32'h08); wr('h50A, 32'h11); rd('h50A, v);
    check("R9 protected override kept", v, 32'h5A);
    rd(2, v); check("R9 override-protect error", v, 32'h20);
    wr(2, 32'hFE); wr(12, 32'h00);

    // R10 start while busy, both bits
    wr(5, 32'h00); wr(6, 32'h09);
    wr(4, 32'h01); wr(4, 32'h08); wait_idle(n);
    check("R10 start ignored while busy", n, UNIT - 1);
    rd(0, v); check("R10 only program done", v, 32'h02);
    wr(0, 32'h3);
    wr(6, 32'h0A); wr(4, 32'h09); wait_idle(n);
    check("R10 both bits program length", n, UNIT);
    rd(0, v); check("R10 program wins", v, 32'h02);
    wr(0, 32'h1); rd(0, v); check("R11 partial clear", v, 32'h02);
    wr(0, 32'h2); rd(0, v); check("R11 done cleared", v, 32'h00);
    rd('h201, v); check("R3 R10 bits 1 and 2 burned", v, 32'h06);

    // R12 readback
    wr(3, 32'hA6); rd(3, v); check("R12 error mask", v, 32'hA6);
    wr(1, 32'h03); rd(1, v); check("R12 status mask", v, 32'h03);
    wr(10, 32'h5C); rd(10, v); check("R12 key", v, 32'h5C);
    wr(13, 32'h81); rd(13, v); check("R12 lock mask", v, 32'h81);
    rd(5, v); check("R12 upper address", v, 32'h00);

    done_flag = 1'b1;
    summary();
  end
endmodule